// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This block turns a decoded load, store or short-form I/O operation of a small 8-bit controller into an effective data-space address. It picks one of three 16-bit pointers, applies the addressing mode, and works out the updated pointer value for the two auto-modifying modes. It then classifies the address into one of four memory regions: the working-register file, the standard I/O window, the extended I/O window and the internal SRAM. An address beyond the end of SRAM is flagged. A mode and pointer pairing that is not allowed is reported and has no side effect.

Every result is registered, so all outputs for an operation presented in one cycle appear together after the next rising clock edge. The surrounding pipeline supplies the current pointer values. It uses the write-back port to update the pointer register pair, with the low byte going to the lower-numbered register of the pair. The SRAM size is a parameter of 512 or 1024 bytes, which puts the last valid address at 0x02FF or 0x04FF.

Top module: `dspace_agu`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Mode code 1 (direct) gives `eff_addr` equal to `direct_addr`. All results of an operation appear after the first rising edge following its presentation.
- R3: Mode code 2 (indirect) gives `eff_addr` equal to the pointer chosen by `ptr_sel`, where 0 selects X, 1 selects Y and 2 selects Z.
- R4: Mode code 3 (displacement) is legal with Y or Z only. It gives the pointer plus the zero-extended 6-bit `index`, modulo 2^16.
- R5: Mode code 4 (pre-decrement) gives pointer minus one (modulo 2^16) as `eff_addr` and as `ptr_wr_data`. It sets `ptr_wr_en` and sets `ptr_wr_sel` to `ptr_sel`.
- R6: Mode code 5 (post-increment) gives the unmodified pointer as `eff_addr` and pointer plus one (modulo 2^16) as `ptr_wr_data`. It sets `ptr_wr_en` and sets `ptr_wr_sel` to `ptr_sel`.
- R7: Mode code 6 (short I/O) gives `index` + 0x20 as `eff_addr`, and `region` is always 4'b0010. `ptr_sel` is ignored.
- R8: `region` is one-hot for in-range addresses: bit 0 for 0x0000-0x001F, bit 1 for 0x0020-0x005F, bit 2 for 0x0060-0x00FF, and bit 3 for 0x0100 up to 0x00FF+SRAM_BYTES.
- R9: An effective address above 0x00FF+SRAM_BYTES sets `out_of_range` and leaves `region` zero.
- R10: `ptr_wr_en` is high only for modes 4 and 5. Otherwise `ptr_wr_en`, `ptr_wr_sel` and `ptr_wr_data` are zero.
- R11: Mode 7, or `ptr_sel` 3 with modes 2-5, or `ptr_sel` 0 with mode 3, sets `illegal`. All other outputs are then zero.
- R12: Mode code 0 (idle) drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Addressing-mode code (0 idle to 7 reserved) |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z, 3 none |
| direct_addr | input | 16 | Full address for direct mode |
| index | input | 6 | Displacement or short I/O index |
| ptr_x | input | 16 | Current X pointer value |
| ptr_y | input | 16 | Current Y pointer value |
| ptr_z | input | 16 | Current Z pointer value |
| eff_addr | output | 16 | Effective data-space address |
| region | output | 4 | One-hot region select (bit0 regs, bit1 I/O, bit2 ext I/O, bit3 SRAM) |
| out_of_range | output | 1 | Address above the last SRAM location |
| illegal | output | 1 | Disallowed mode and pointer pairing |
| ptr_wr_en | output | 1 | Pointer write-back enable |
| ptr_wr_sel | output | 2 | Pointer being written back |
| ptr_wr_data | output | 16 | New pointer value |

## Verification
Every result, including the write-back triple and the region flags, is due exactly one rising edge after the operation is applied. There is no multi-cycle state, so each operation's outcome is complete at that single edge. The bench drives each operation on a falling edge and samples all outputs just after the following rising edge. It then compares them as a whole against a model computed from the requirements, before the next operation is driven. The reset and idle cases use the same one-edge timing.

// File: rtl/dspace_agu_pkg.sv
package dspace_agu_pkg;

    localparam int AW    = 16;
    localparam int IDX_W = 6;
    localparam int NREG  = 4;

    localparam logic [AW-1:0] IO_BASE   = 16'h0020;
    localparam logic [AW-1:0] EXT_BASE  = 16'h0060;
    localparam logic [AW-1:0] SRAM_BASE = 16'h0100;

    typedef enum logic [2:0] {
        AM_IDLE    = 3'd0,
        AM_DIRECT  = 3'd1,
        AM_IND     = 3'd2,
        AM_DISP    = 3'd3,
        AM_PREDEC  = 3'd4,
        AM_POSTINC = 3'd5,
        AM_IOSHORT = 3'd6,
        AM_RSVD    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_NONE = 2'd3
    } psel_e;

    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [NREG-1:0] region;
        logic            oor;
        logic            illegal;
        logic            wr_en;
        logic [1:0]      wr_sel;
        logic [AW-1:0]   wr_data;
    } agu_res_t;

    function automatic logic mode_uses_ptr(amode_e m);
        return (m == AM_IND) || (m == AM_DISP) ||
               (m == AM_PREDEC) || (m == AM_POSTINC);
    endfunction

    function automatic logic pairing_ok(amode_e m, psel_e s);
        if (m == AM_RSVD)
            return 1'b0;
        if (mode_uses_ptr(m) && s == PS_NONE)
            return 1'b0;
        if (m == AM_DISP && s == PS_X)
            return 1'b0;
        return 1'b1;
    endfunction

    // lower bound of region i in the data space
    function automatic logic [AW-1:0] region_lo(int i);
        case (i)
            0:       return '0;
            1:       return IO_BASE;
            2:       return EXT_BASE;
            default: return SRAM_BASE;
        endcase
    endfunction

endpackage

// File: rtl/dspace_ptr_sel.sv
module dspace_ptr_sel
    import dspace_agu_pkg::*;
(
    input  psel_e         sel,
    input  logic [AW-1:0] ptr_x,
    input  logic [AW-1:0] ptr_y,
    input  logic [AW-1:0] ptr_z,
    output logic [AW-1:0] ptr
);
    always_comb begin
        unique case (sel)
            PS_X:    ptr = ptr_x;
            PS_Y:    ptr = ptr_y;
            PS_Z:    ptr = ptr_z;
            default: ptr = '0;
        endcase
    end
endmodule

// File: rtl/dspace_addr_calc.sv
module dspace_addr_calc
    import dspace_agu_pkg::*;
(
    input  amode_e           mode,
    input  psel_e            sel,
    input  logic [AW-1:0]    direct_addr,
    input  logic [IDX_W-1:0] index,
    input  logic [AW-1:0]    ptr,
    output logic [AW-1:0]    addr,
    output logic             active,
    output logic             illegal,
    output logic             wr_en,
    output logic [1:0]       wr_sel,
    output logic [AW-1:0]    wr_data
);
    localparam int PAD = AW - IDX_W;

    logic [AW-1:0] idx_ext;
    logic [AW-1:0] ptr_dec;
    logic [AW-1:0] ptr_inc;
    logic          ok;

    assign idx_ext = {{PAD{1'b0}}, index};
    assign ptr_dec = ptr - 1'b1;
    assign ptr_inc = ptr + 1'b1;
    assign ok      = pairing_ok(mode, sel);

    always_comb begin
        addr    = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        wr_sel  = 2'd0;
        illegal = ~ok;
        active  = ok && (mode != AM_IDLE);
        if (ok) begin
            unique case (mode)
                AM_DIRECT:  addr = direct_addr;
                AM_IND:     addr = ptr;
                AM_DISP:    addr = ptr + idx_ext;
                AM_PREDEC: begin
                    addr    = ptr_dec;
                    wr_en   = 1'b1;
                    wr_data = ptr_dec;
                    wr_sel  = sel;
                end
                AM_POSTINC: begin
                    addr    = ptr;
                    wr_en   = 1'b1;
                    wr_data = ptr_inc;
                    wr_sel  = sel;
                end
                AM_IOSHORT: addr = IO_BASE + idx_ext;
                default:    addr = '0;
            endcase
        end
    end
endmodule

// File: rtl/dspace_region_dec.sv
module dspace_region_dec
    import dspace_agu_pkg::*;
#(
    parameter int SRAM_BYTES = 1024
)(
    input  logic [AW-1:0]   addr,
    input  logic            active,
    output logic [NREG-1:0] region,
    output logic            oor
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(int'(SRAM_BASE) + SRAM_BYTES - 1);

    logic [AW-1:0] hi_bound [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == NREG - 1) begin : g_top
            assign hi_bound[g] = LAST_ADDR;
        end else begin : g_mid
            assign hi_bound[g] = region_lo(g + 1) - 1'b1;
        end
        assign region[g] = active && (addr >= region_lo(g)) && (addr <= hi_bound[g]);
    end

    assign oor = active && (addr > LAST_ADDR);
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
    import dspace_agu_pkg::*;
#(
    parameter int SRAM_BYTES = 1024
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode,
    input  logic [1:0]  ptr_sel,
    input  logic [15:0] direct_addr,
    input  logic [5:0]  index,
    input  logic [15:0] ptr_x,
    input  logic [15:0] ptr_y,
    input  logic [15:0] ptr_z,
    output logic [15:0] eff_addr,
    output logic [3:0]  region,
    output logic        out_of_range,
    output logic        illegal,
    output logic        ptr_wr_en,
    output logic [1:0]  ptr_wr_sel,
    output logic [15:0] ptr_wr_data
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(int'(SRAM_BASE) + SRAM_BYTES - 1);

    amode_e        mode_e;
    psel_e         sel_e;
    logic [AW-1:0] ptr_cur;
    agu_res_t      nxt;
    agu_res_t      res_q;
    logic          act;

    assign mode_e = amode_e'(mode);
    assign sel_e  = psel_e'(ptr_sel);

    dspace_ptr_sel u_psel (
        .sel   (sel_e),
        .ptr_x (ptr_x),
        .ptr_y (ptr_y),
        .ptr_z (ptr_z),
        .ptr   (ptr_cur)
    );

    dspace_addr_calc u_calc (
        .mode        (mode_e),
        .sel         (sel_e),
        .direct_addr (direct_addr),
        .index       (index),
        .ptr         (ptr_cur),
        .addr        (nxt.addr),
        .active      (act),
        .illegal     (nxt.illegal),
        .wr_en       (nxt.wr_en),
        .wr_sel      (nxt.wr_sel),
        .wr_data     (nxt.wr_data)
    );

    dspace_region_dec #(.SRAM_BYTES(SRAM_BYTES)) u_rdec (
        .addr   (nxt.addr),
        .active (act),
        .region (nxt.region),
        .oor    (nxt.oor)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign eff_addr     = res_q.addr;
    assign region       = res_q.region;
    assign out_of_range = res_q.oor;
    assign illegal      = res_q.illegal;
    assign ptr_wr_en    = res_q.wr_en;
    assign ptr_wr_sel   = res_q.wr_sel;
    assign ptr_wr_data  = res_q.wr_data;

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region)); // R8
    AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (region == 4'b0000 && eff_addr > LAST_ADDR)); // R9
    AST_SRAM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        region[3] |-> (eff_addr >= SRAM_BASE && eff_addr <= LAST_ADDR)); // R8
    AST_WR_ONLY_AUTOMOD: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'd4 && mode != 3'd5) |=> !ptr_wr_en); // R10
    AST_ILLEGAL_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!ptr_wr_en && region == 4'b0000 && eff_addr == '0)); // R11
    AST_IOSHORT_REGION: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd6) |=> (region == 4'b0010)); // R7
    AST_PREDEC_ADDR_EQ_WB: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && ptr_sel != 2'd3) |=> (ptr_wr_en && ptr_wr_data == eff_addr)); // R5
    AST_POSTINC_WB_PLUS1: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && ptr_sel != 2'd3) |=> (ptr_wr_en && ptr_wr_data == eff_addr + 16'd1)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0) |=> (eff_addr == '0 && region == '0 && !illegal && !ptr_wr_en)); // R12
endmodule

// File: tb/dspace_agu_test.sv
`timescale 1ns/1ps
module dspace_agu_test;
    localparam int SRAM_BYTES = 1024;
    localparam int LAST = 16'h0100 + SRAM_BYTES - 1;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode;
    logic [1:0]  ptr_sel;
    logic [15:0] direct_addr;
    logic [5:0]  index;
    logic [15:0] ptr_x, ptr_y, ptr_z;
    logic [15:0] eff_addr;
    logic [3:0]  region;
    logic        out_of_range, illegal, ptr_wr_en;
    logic [1:0]  ptr_wr_sel;
    logic [15:0] ptr_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dspace_agu #(.SRAM_BYTES(SRAM_BYTES)) uut (
        .clk(clk), .rst(rst), .mode(mode), .ptr_sel(ptr_sel),
        .direct_addr(direct_addr), .index(index),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .eff_addr(eff_addr), .region(region), .out_of_range(out_of_range),
        .illegal(illegal), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
        .ptr_wr_data(ptr_wr_data)
    );

    // expected packed result: {addr, region, oor, illegal, wr_en, wr_sel, wr_data}
    function automatic logic [40:0] model(logic [2:0] m, logic [1:0] s, logic [15:0] da,
                                          logic [5:0] ix, logic [15:0] px, logic [15:0] py,
                                          logic [15:0] pz);
        logic [15:0] p, a, wd;
        logic [3:0]  rg;
        logic        oo, il, we, ptr_mode;
        logic [1:0]  ws;
        p  = (s == 2'd0) ? px : (s == 2'd1) ? py : (s == 2'd2) ? pz : 16'h0;
        a = '0; wd = '0; rg = '0; oo = 0; we = 0; ws = '0;
        ptr_mode = (m >= 3'd2 && m <= 3'd5);
        il = (m == 3'd7) || (ptr_mode && s == 2'd3) || (m == 3'd3 && s == 2'd0);
        if (!il && m != 3'd0) begin
            case (m)
                3'd1: a = da;
                3'd2: a = p;
                3'd3: a = p + {10'd0, ix};
                3'd4: begin a = p - 16'd1; wd = a; we = 1; ws = s; end
                3'd5: begin a = p; wd = p + 16'd1; we = 1; ws = s; end
                default: a = {10'd0, ix} + 16'h0020;
            endcase
            if (a <= 16'h001F)      rg = 4'b0001;
            else if (a <= 16'h005F) rg = 4'b0010;
            else if (a <= 16'h00FF) rg = 4'b0100;
            else if (a <= 16'(LAST)) rg = 4'b1000;
            else oo = 1;
        end
        return {a, rg, oo, il, we, ws, wd};
    endfunction

    task automatic check(string tag);
        logic [40:0] exp_v, act_v;
        exp_v = model(mode, ptr_sel, direct_addr, index, ptr_x, ptr_y, ptr_z);
        @(posedge clk); #1;
        act_v = {eff_addr, region, out_of_range, illegal, ptr_wr_en, ptr_wr_sel, ptr_wr_data};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (mode=%0d sel=%0d)", tag, act_v, exp_v, mode, ptr_sel);
        end
        @(negedge clk);
    endtask

    task automatic op(logic [2:0] m, logic [1:0] s, logic [15:0] da, logic [5:0] ix,
                      logic [15:0] px, logic [15:0] py, logic [15:0] pz, string tag);
        mode = m; ptr_sel = s; direct_addr = da; index = ix;
        ptr_x = px; ptr_y = py; ptr_z = pz;
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst = 1'b1;
        mode = 3'd1; ptr_sel = 2'd0; direct_addr = 16'h0123; index = 6'h3F;
        ptr_x = 16'h0200; ptr_y = 16'h0300; ptr_z = 16'h0400;
        @(negedge clk);
        @(posedge clk); #1;
        n_tests++;
        if ({eff_addr, region, out_of_range, illegal, ptr_wr_en, ptr_wr_sel, ptr_wr_data} !== '0) begin
            n_fail++;
            $display("FAIL R1 actual=%h expected=0", eff_addr);
        end
        @(negedge clk);
        rst = 1'b0;

        // directed corner cases
        op(3'd1, 2'd3, 16'h04FF, 6'd0, 0, 0, 0, "R2 direct last sram");
        op(3'd1, 2'd0, 16'h0500, 6'd0, 0, 0, 0, "R9 direct just past sram");
        op(3'd1, 2'd1, 16'hFFFF, 6'd0, 0, 0, 0, "R9 direct top");
        op(3'd1, 2'd0, 16'h001F, 6'd0, 0, 0, 0, "R8 regfile top");
        op(3'd1, 2'd0, 16'h0020, 6'd0, 0, 0, 0, "R8 io bottom");
        op(3'd1, 2'd0, 16'h005F, 6'd0, 0, 0, 0, "R8 io top");
        op(3'd1, 2'd0, 16'h0060, 6'd0, 0, 0, 0, "R8 ext bottom");
        op(3'd1, 2'd0, 16'h00FF, 6'd0, 0, 0, 0, "R8 ext top");
        op(3'd1, 2'd0, 16'h0100, 6'd0, 0, 0, 0, "R8 sram bottom");
        op(3'd2, 2'd0, 16'h0, 6'd0, 16'h001A, 16'h0300, 16'h0400, "R3 indirect X");
        op(3'd2, 2'd2, 16'h0, 6'd0, 16'h001A, 16'h0300, 16'h0070, "R3 indirect Z");
        op(3'd3, 2'd1, 16'h0, 6'd63, 0, 16'h04C0, 0, "R4 disp Y max offset");
        op(3'd3, 2'd2, 16'h0, 6'd5, 0, 0, 16'hFFFE, "R4 disp Z wrap");
        op(3'd3, 2'd0, 16'h0, 6'd5, 16'h0200, 0, 0, "R11 disp with X");
        op(3'd4, 2'd0, 16'h0, 6'd0, 16'h0000, 0, 0, "R5 predec wrap");
        op(3'd4, 2'd1, 16'h0, 6'd0, 0, 16'h0101, 0, "R5 predec Y");
        op(3'd5, 2'd2, 16'h0, 6'd0, 0, 0, 16'hFFFF, "R6 postinc wrap");
        op(3'd5, 2'd0, 16'h0, 6'd0, 16'h04FF, 0, 0, "R6 postinc X");
        op(3'd5, 2'd3, 16'h0, 6'd0, 1, 2, 3, "R11 postinc no ptr");
        op(3'd6, 2'd3, 16'hFFFF, 6'd0, 0, 0, 0, "R7 io index 0");
        op(3'd6, 2'd1, 16'h0, 6'd63, 0, 0, 0, "R7 io index 63");
        op(3'd7, 2'd1, 16'h0100, 6'd1, 0, 16'h0200, 0, "R11 reserved mode");
        op(3'd0, 2'd1, 16'h0100, 6'd1, 0, 16'h0200, 0, "R12 idle");
        op(3'd2, 2'd1, 16'h0, 6'd0, 16'hAAAA, 16'h0800, 16'h5555, "R9 indirect past sram");

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [15:0] rx, ry, rz, rd;
            rx = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16'h0560);
            ry = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16'h0560);
            rz = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16'h0560);
            rd = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16'h0560);
            op(3'($urandom), 2'($urandom), rd, 6'($urandom), rx, ry, rz,
               "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
        end

        // reset mid-stream clears outputs again
        mode = 3'd5; ptr_sel = 2'd0; ptr_x = 16'h0200;
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        n_tests++;
        if ({eff_addr, ptr_wr_en, region} !== '0) begin
            n_fail++;
            $display("FAIL R1 actual=%h/%b expected=0", eff_addr, ptr_wr_en);
        end
        rst = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule